// File: doc/BRIEF.md
# SPI Serial EEPROM Device Emulator

This block is the device side of a byte-wide serial EEPROM on an SPI link in mode 0. A host selects it with an active-low chip select and clocks in an 8-bit opcode, a 16-bit address and data. Read data comes back MSB first on the serial output. The system clock oversamples the serial clock, chip select, data input and hold pins. The block then works only on edges that it detects itself, with no second clock domain. The storage array holds 2^MEM_AW bytes (4096 by default).

A write is gathered in a page buffer of 2^PAGE_AW bytes (32 by default). It is copied into the array during a programming interval that lasts WRITE_CYCLES system clocks. During that interval the status register reports the cycle as busy, and array reads are refused. Writes are allowed only after a separate write-enable transaction has completed. Each completed programming interval clears the enable again. A hold input can pause a transfer at any bit and resume it later at the same point.

Top module: `spi_eeprom_emu`

## Requirements
- R1: After reset, and whenever no read or status data is being shifted out, so_oe_o is 0 and so_o is 0. Both the enable latch and the busy flag reset to 0.
- R2: Opcode 06h sets the write enable latch (status bit 1). The latch sets only when chip select rises directly after the eighth opcode bit. Any further bit in the same select period cancels the set.
- R3: A write opcode (02h) issued while the enable latch is clear has no effect on the array or the status.
- R4: Opcode and address are shifted in MSB first. The address is 16 bits, and only its low MEM_AW bits select a byte. Read data (opcode 03h) is shifted out MSB first.
- R5: A read continues through consecutive addresses for as long as clocks arrive, and wraps from the highest address to 0.
- R6: Write data fills the page that contains the start address. Bytes that pass the page end wrap to the start of the same page. A later byte for the same location replaces the earlier one.
- R7: Programming starts only when chip select rises after a whole number of data bytes, at least one. Otherwise the array, the busy flag and the enable latch are left as they were.
- R8: During programming, status reads (05h) return busy in bit 0 and the enable latch in bit 1. A read opcode produces no output. When programming ends, busy and the enable latch both clear, and the new data is readable.
- R9: While hold_ni is low, serial clock edges are ignored and so_oe_o is 0. After release, the transfer continues from the same bit.
- R10: Opcode 04h clears the enable latch when chip select rises after exactly eight opcode bits.
- R11: An unknown opcode produces no output. All further bits in that select period are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, input sampled on its rising edge |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out, changes after falling serial clock edges |
| so_oe_o | output | 1 | High while so_o carries read or status data |

## Verification
The bench builds the block with MEM_AW=8, PAGE_AW=3 and WRITE_CYCLES=2000. The 256-byte array lets a read cross from address FFh to 00h in a few bytes. With an 8-byte page, a ten-byte write wraps inside its page and overwrites two of its own bytes. The long programming interval leaves enough time to issue a refused read and then a status read while busy is still set. Address bytes with nonzero upper bits show that those bits are ignored.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_RDSR,
    ST_ARM,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/spi_ee_front.sv
module spi_ee_front (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic cs_idle_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o,
  output logic hold_o
);
  // bit order {cs, sck, si, hold}
  localparam int N = 4;
  localparam logic [N-1:0] RST_V = 4'b1001;

  logic [N-1:0] raw, s1_q, s2_q;
  logic         cs_prev_q, sck_prev_q;

  assign raw = {cs_ni, sck_i, si_i, hold_ni};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q       <= RST_V;
      s2_q       <= RST_V;
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      s1_q       <= raw;
      s2_q       <= s1_q;
      cs_prev_q  <= s2_q[3];
      sck_prev_q <= s2_q[2];
    end
  end

  assign cs_idle_o  = s2_q[3];
  assign cs_fall_o  = cs_prev_q & ~s2_q[3];
  assign cs_rise_o  = ~cs_prev_q & s2_q[3];
  assign sck_rise_o = ~sck_prev_q & s2_q[2];
  assign sck_fall_o = sck_prev_q & ~s2_q[2];
  assign si_o       = s2_q[1];
  assign hold_o     = ~s2_q[0];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_ee_pgbuf.sv
module spi_ee_pgbuf #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] wcol_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] rcol_i,
  output logic [7:0]    rdata_o,
  output logic          rvld_o
);
  localparam int N = 1 << AW;

  logic [7:0]   dat [N];
  logic [N-1:0] vld;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [7:0] d_q;
    logic       v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= 8'h00;
        v_q <= 1'b0;
      end else if (clr_i) begin
        v_q <= 1'b0;
      end else if (we_i && wcol_i == AW'(g)) begin
        d_q <= wdata_i;
        v_q <= 1'b1;
      end
    end
    assign dat[g] = d_q;
    assign vld[g] = v_q;
  end

  assign rdata_o = dat[rcol_i];
  assign rvld_o  = vld[rcol_i];
endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu
  import spi_ee_pkg::*;
#(
  parameter int MEM_AW       = 12,
  parameter int PAGE_AW      = 5,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int CW         = $clog2(WRITE_CYCLES + 1);

  logic cs_idle, cs_fall, cs_rise, sck_rise, sck_fall, si_s, hold_act;
  logic rise_g, fall_g;

  spi_ee_front u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .sck_i     (sck_i),
    .si_i      (si_i),
    .hold_ni   (hold_ni),
    .cs_idle_o (cs_idle),
    .cs_fall_o (cs_fall),
    .cs_rise_o (cs_rise),
    .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall),
    .si_o      (si_s),
    .hold_o    (hold_act)
  );

  assign rise_g = sck_rise & ~hold_act & ~cs_idle;
  assign fall_g = sck_fall & ~hold_act & ~cs_idle;

  st_e                st_q;
  logic [3:0]         bit_q;
  logic [MEM_AW-2:0]  rx_q;
  logic [MEM_AW-1:0]  rx_nxt, addr_q, rd_addr, arr_waddr;
  logic [7:0]         tx_q, status, rd_data, pb_rdata, tx_src;
  logic               wel_q, wip_q, wr_q, arm_q, any_q;
  logic [PAGE_AW-1:0] col_q, prog_col;
  logic [CW-1:0]      cnt_q;
  logic               byte_end, addr_end, pb_clr, pb_we, pb_rvld, arr_we, rd_st;

  assign rx_nxt    = {rx_q, si_s};
  assign byte_end  = bit_q == 4'd7;
  assign addr_end  = (st_q == ST_ADDR) && (bit_q == 4'd15);
  assign status    = {6'd0, wel_q, wip_q};
  assign rd_addr   = (st_q == ST_ADDR) ? rx_nxt : addr_q;
  assign tx_src    = (st_q == ST_RDSR) ? status : rd_data;
  assign pb_clr    = rise_g && addr_end && wr_q;
  assign pb_we     = rise_g && (st_q == ST_WDATA) && byte_end;
  assign prog_col  = cnt_q[PAGE_AW-1:0];
  assign arr_we    = wip_q && (cnt_q < CW'(PAGE_BYTES)) && pb_rvld;
  assign arr_waddr = {addr_q[MEM_AW-1:PAGE_AW], prog_col};
  assign rd_st     = st_q == ST_RDATA;

  spi_ee_pgbuf #(.AW(PAGE_AW)) u_pgbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pb_clr),
    .we_i   (pb_we),
    .wcol_i (col_q),
    .wdata_i(rx_nxt[7:0]),
    .rcol_i (prog_col),
    .rdata_o(pb_rdata),
    .rvld_o (pb_rvld)
  );

  spi_ee_array #(.AW(MEM_AW)) u_array (
    .clk_i  (clk_i),
    .we_i   (arr_we),
    .waddr_i(arr_waddr),
    .wdata_i(pb_rdata),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      rx_q   <= '0;
      addr_q <= '0;
      tx_q   <= '0;
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
      wr_q   <= 1'b0;
      arm_q  <= 1'b0;
      any_q  <= 1'b0;
      col_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (cs_fall) begin
        st_q  <= ST_CMD;
        bit_q <= '0;
      end else if (cs_rise) begin
        if (st_q == ST_ARM) wel_q <= arm_q;
        // commit only on a byte boundary with data present
        if (st_q == ST_WDATA && bit_q == 4'd0 && any_q) begin
          wip_q <= 1'b1;
          cnt_q <= '0;
        end
        st_q <= ST_IDLE;
      end else if (rise_g) begin
        rx_q <= rx_nxt[MEM_AW-2:0];
        unique case (st_q)
          ST_CMD: begin
            if (byte_end) begin
              bit_q <= '0;
              unique case (rx_nxt[7:0])
                OP_READ: begin
                  st_q <= wip_q ? ST_SKIP : ST_ADDR;
                  wr_q <= 1'b0;
                end
                OP_WRITE: begin
                  st_q <= (wel_q && !wip_q) ? ST_ADDR : ST_SKIP;
                  wr_q <= 1'b1;
                end
                OP_WREN, OP_WRDI: begin
                  st_q  <= wip_q ? ST_SKIP : ST_ARM;
                  arm_q <= rx_nxt[7:0] == OP_WREN;
                end
                OP_RDSR: begin
                  st_q <= ST_RDSR;
                  tx_q <= status;
                end
                default: st_q <= ST_SKIP;
              endcase
            end else begin
              bit_q <= bit_q + 4'd1;
            end
          end
          ST_ADDR: begin
            bit_q <= bit_q + 4'd1;
            if (addr_end) begin
              addr_q <= rx_nxt;
              if (wr_q) begin
                st_q  <= ST_WDATA;
                col_q <= rx_nxt[PAGE_AW-1:0];
                any_q <= 1'b0;
              end else begin
                st_q <= ST_RDATA;
                tx_q <= rd_data;
              end
            end
          end
          ST_RDATA: begin
            bit_q <= byte_end ? 4'd0 : bit_q + 4'd1;
            if (byte_end) addr_q <= addr_q + 1'b1;
          end
          ST_RDSR: bit_q <= byte_end ? 4'd0 : bit_q + 4'd1;
          ST_WDATA: begin
            bit_q <= byte_end ? 4'd0 : bit_q + 4'd1;
            if (byte_end) begin
              any_q <= 1'b1;
              col_q <= col_q + 1'b1;
            end
          end
          ST_ARM: st_q <= ST_SKIP;
          default: ;
        endcase
      end else if (fall_g && (st_q == ST_RDATA || st_q == ST_RDSR)) begin
        tx_q <= (bit_q == 4'd0) ? tx_src : {tx_q[6:0], 1'b0};
      end

      if (wip_q) begin
        if (cnt_q == CW'(WRITE_CYCLES - 1)) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign so_oe_o = ~cs_idle & ~hold_act & (rd_st | (st_q == ST_RDSR));
  assign so_o    = so_oe_o & tx_q[7];
endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic so_o,
  input logic so_oe_o,
  input logic cs_idle_i,
  input logic hold_i,
  input logic wip_i,
  input logic wel_i,
  input logic rd_i
);
  // R1
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_idle_i && $past(cs_idle_i)) |-> !so_oe_o);

  // R1
  so_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_oe_o |-> !so_o);

  // R9
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !so_oe_o);

  // R8
  no_rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_i |-> !rd_i);

  // R8
  wel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> !wel_i);

  // R7
  wip_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(wel_i));
endmodule

bind spi_eeprom_emu spi_ee_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .so_o     (so_o),
  .so_oe_o  (so_oe_o),
  .cs_idle_i(cs_idle),
  .hold_i   (hold_act),
  .wip_i    (wip_q),
  .wel_i    (wel_q),
  .rd_i     (rd_st)
);

// File: tb/spi_eeprom_emu_tb_top.sv
module spi_eeprom_emu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 2000;
  localparam int HALF       = 8;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic hold_n = 1'b1;
  logic so, so_oe;

  int checks = 0;
  int fails = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic oe_any;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_emu #(.MEM_AW(8), .PAGE_AW(3), .WRITE_CYCLES(WCYC)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_ni  (cs_n),
    .sck_i  (sck),
    .si_i   (si),
    .hold_ni(hold_n),
    .so_o   (so),
    .so_oe_o(so_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_bit(input logic b, output logic o);
    si = b;
    wait_clk(HALF);
    o = so;
    if (so_oe) oe_any = 1'b1;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    logic o;
    for (int i = 7; i >= 0; i--) begin
      do_bit(d[i], o);
      q[i] = o;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_hi();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] q;
    cs_lo();
    xfer(op, q);
    cs_hi();
  endtask

  task automatic rd_sr(output logic [7:0] s);
    logic [7:0] q;
    cs_lo();
    xfer(8'h05, q);
    xfer(8'h00, s);
    cs_hi();
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic [7:0] q;
    cs_lo();
    xfer(8'h02, q);
    xfer(a[15:8], q);
    xfer(a[7:0], q);
    for (int i = 0; i < n; i++) xfer(wbuf[i], q);
    cs_hi();
  endtask

  task automatic wr_commit(input logic [15:0] a, input int n);
    op1(8'h06);
    wr(a, n);
    wait_clk(WCYC + 20);
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] q;
    cs_lo();
    xfer(8'h03, q);
    xfer(a[15:8], q);
    xfer(a[7:0], q);
    oe_any = 1'b0;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, q);
      rbuf[i] = q;
    end
    cs_hi();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 oe after reset", so_oe, 1'b0);
    chk("R1 so after reset", so, 1'b0);
    rd_sr(s);
    chk("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_wel();
    logic [7:0] s, q;
    op1(8'h06);
    rd_sr(s);
    chk("R2 enable latch set", s, 8'h02);
    op1(8'h04);
    rd_sr(s);
    chk("R10 enable latch cleared", s, 8'h00);
    cs_lo();
    xfer(8'h06, q);
    xfer(8'h00, q);
    cs_hi();
    rd_sr(s);
    chk("R2 extra bits cancel set", s, 8'h00);
  endtask

  task automatic t_nowel();
    logic [7:0] s;
    wbuf[0] = 8'h11;
    wr_commit(16'h0010, 1);
    wbuf[0] = 8'hA5;
    wr(16'h0010, 1);
    rd_sr(s);
    chk("R3 no busy without enable", s, 8'h00);
    rd(16'h0010, 1);
    chk("R3 array unchanged", rbuf[0], 8'h11);
  endtask

  task automatic t_byte();
    wbuf[0] = 8'h3C;
    wr_commit(16'hF012, 1);
    rd(16'h0012, 1);
    chk("R4 byte readback", rbuf[0], 8'h3C);
    rd(16'h5512, 1);
    chk("R4 upper address bits ignored", rbuf[0], 8'h3C);
  endtask

  task automatic t_seq();
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h80 + 8'(i);
    wr_commit(16'h00F8, 8);
    wbuf[0] = 8'h40;
    wbuf[1] = 8'h41;
    wr_commit(16'h0000, 2);
    rd(16'h00FE, 4);
    chk("R5 seq byte0", rbuf[0], 8'h86);
    chk("R5 seq byte1", rbuf[1], 8'h87);
    chk("R5 wrap to zero", rbuf[2], 8'h40);
    chk("R5 after wrap", rbuf[3], 8'h41);
  endtask

  task automatic t_page();
    logic [7:0] exp [8];
    wbuf[0] = 8'hEE;
    wr_commit(16'h0022, 1);
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hC0 + 8'(i);
    wr_commit(16'h0023, 10);
    exp[0] = 8'hC5; exp[1] = 8'hC6; exp[2] = 8'hC7; exp[3] = 8'hC8;
    exp[4] = 8'hC9; exp[5] = 8'hC2; exp[6] = 8'hC3; exp[7] = 8'hC4;
    rd(16'h0020, 8);
    for (int i = 0; i < 8; i++) chk("R6 page wrap", rbuf[i], exp[i]);
  endtask

  task automatic t_abort();
    logic [7:0] s, q;
    wbuf[0] = 8'h55;
    wr_commit(16'h0040, 1);
    op1(8'h06);
    cs_lo();
    xfer(8'h02, q);
    xfer(8'h00, q);
    xfer(8'h40, q);
    xfer(8'h99, q);
    for (int i = 0; i < 3; i++) do_bit(1'b1, q[0]);
    cs_hi();
    rd_sr(s);
    chk("R7 partial byte no cycle", s, 8'h02);
    wr(16'h0040, 0);
    rd_sr(s);
    chk("R7 no data no cycle", s, 8'h02);
    rd(16'h0040, 1);
    chk("R7 array unchanged", rbuf[0], 8'h55);
    op1(8'h04);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    op1(8'h06);
    wbuf[0] = 8'h77;
    wr(16'h0050, 1);
    rd(16'h0050, 1);
    chk("R8 read refused while busy", oe_any, 1'b0);
    rd_sr(s);
    chk("R8 status while busy", s, 8'h03);
    wait_clk(WCYC);
    rd_sr(s);
    chk("R8 status after cycle", s, 8'h00);
    rd(16'h0050, 1);
    chk("R8 data after cycle", rbuf[0], 8'h77);
  endtask

  task automatic t_hold();
    logic [7:0] q, v;
    logic o;
    cs_lo();
    xfer(8'h03, q);
    xfer(8'h00, q);
    xfer(8'h12, q);
    for (int i = 7; i >= 4; i--) begin
      do_bit(1'b0, o);
      v[i] = o;
    end
    wait_clk(HALF);
    hold_n = 1'b0;
    wait_clk(HALF);
    chk("R9 oe low in hold", so_oe, 1'b0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 3; i >= 0; i--) begin
      do_bit(1'b0, o);
      v[i] = o;
    end
    cs_hi();
    chk("R9 byte intact across hold", v, 8'h3C);
  endtask

  task automatic t_unknown();
    logic [7:0] q, s;
    oe_any = 1'b0;
    cs_lo();
    xfer(8'hAB, q);
    xfer(8'h06, q);
    cs_hi();
    chk("R11 no output for unknown opcode", oe_any, 1'b0);
    rd_sr(s);
    chk("R11 trailing bits ignored", s, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_wel();
    t_nowel();
    t_byte();
    t_seq();
    t_page();
    t_abort();
    t_busy();
    t_hold();
    t_unknown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", WDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule